// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block feeds a display pipeline with 32-bit framebuffer words. It does not take a base address and a length from registers. Instead it follows a chain of descriptors held in memory. Each descriptor is four 32-bit words. The first word links to the next descriptor, the second gives the source buffer address, the third is a frame identifier and the fourth is a command word. The command word holds the transfer length in words and per-frame flag requests. Software writes the address of the first descriptor into the head-pointer register and sets the run bit. From then on the fetcher loads descriptors, streams each buffer into an internal word FIFO through length-tagged read bursts, and moves to the linked descriptor when a frame ends.

A descriptor that links to itself makes the same buffer refetch every frame, so the display refreshes with no processor involvement. The display timing side pops one word per cycle while its data-enable is high. If the FIFO is empty at that moment the output word is zero. When underrun detection is enabled, that event is also recorded as a sticky status flag. The fields of the descriptor just loaded can be read back from read-only registers.

Top module: `dfetch_top`

## Requirements
- R1: When the run bit (control bit 3) is set, the fetcher issues one 4-word read at the head-pointer address (register 0x40). It takes the returned words in this order: link address, source address, frame ID, command. A request holds its address and length while the ready input is low.
- R2: Registers 0x44, 0x48 and 0x4C return the loaded source address, frame ID and command word. Writes to them have no effect. Register 0x40 is readable and writable.
- R3: The transfer length is command bits 23:0, counted in words. That many words are read upward from the source address and delivered on the pixel output in address order.
- R4: Control bits 29:28 set the burst size. The value 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. The last burst of a frame is cut down to the words that remain, so a burst never runs past the end of the transfer.
- R5: A data burst is requested only while the FIFO has free space for a burst of the full configured size.
- R6: Command bit 31 sets status bit 1 when the descriptor is loaded. Command bit 30 sets status bit 2 when the remaining count reaches zero. This includes a zero-length descriptor, which issues no data reads.
- R7: At the end of a frame the head pointer takes the link address. If run is still set, the next descriptor is fetched; a self-linked descriptor refetches its buffer indefinitely. If run is clear, fetching stops after the current frame.
- R8: A cycle with pixel data-enable high and the FIFO empty drives a zero output word. It sets status bit 0 (sticky) only if control bit 26 is set.
- R9: The interrupt output is status bit 1 OR status bit 2 OR (status bit 0 AND control bit 11). A write to register 0x34 clears every status bit written as 0.
- R10: After reset, the control, status and head-pointer registers read zero, no request is pending, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| memReqValid | output | 1 | Read burst request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Byte address of the first word of the burst |
| memReqLen | output | 5 | Burst length in words (1 to 16) |
| memRspValid | input | 1 | A read word is returned |
| memRspData | input | 32 | Returned read word |
| pixDe | input | 1 | Display data-enable; pops one word |
| pixData | output | 32 | Word delivered to the display, zero when empty |
| irq | output | 1 | Interrupt request |

## Verification
Single-descriptor frames are run across every burst setting. The lengths are chosen to be shorter than, equal to, an exact multiple of, and not a multiple of the burst size. The number and size of requests then show whether the last burst is cut down correctly and never overshoots. Alternate frames stall the memory's ready signal, which separates request holding from address stepping. A frame larger than the FIFO is left undrained and then drained in steps, to show that a burst waits for full-burst room and does not start on partial room. A two-descriptor chain whose tail links to itself shows in-order link following and repeated refresh. Zero-length frames and data-enable pulses with the FIFO empty cover the flags and the interrupt mask.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
  localparam int unsigned MAX_BURST = 16;
  localparam int unsigned BLEN_W    = $clog2(MAX_BURST) + 1;

  localparam logic [7:0] OFS_CTRL = 8'h30;
  localparam logic [7:0] OFS_STAT = 8'h34;
  localparam logic [7:0] OFS_HEAD = 8'h40;
  localparam logic [7:0] OFS_SRC  = 8'h44;
  localparam logic [7:0] OFS_FID  = 8'h48;
  localparam logic [7:0] OFS_CMD  = 8'h4C;

  localparam int unsigned CTRL_RUN  = 3;
  localparam int unsigned CTRL_UIRQ = 11;
  localparam int unsigned CTRL_UDET = 26;
  localparam int unsigned CTRL_BLO  = 28;
  localparam int unsigned CMD_SOF   = 31;
  localparam int unsigned CMD_EOF   = 30;

  // word order inside a descriptor is fixed by the memory layout
  typedef enum logic [1:0] {W_LINK, W_SRC, W_FID, W_CMD} descWord_e;

  typedef struct packed {
    logic      capture;
    descWord_e word;
    logic      push;
    logic      markSof;
    logic      markEof;
    logic      advance;
  } fetchStrobes_t;
endpackage

// File: rtl/dfetch_ctrl.sv
module dfetch_ctrl
  import dfetch_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LEN_W      = 24,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic [1:0]           burstSel,
  input  logic [31:0]          headPtr,
  input  logic [31:0]          srcAddr,
  input  logic [LEN_W-1:0]     cmdLen,
  input  logic                 cmdSof,
  input  logic                 cmdEof,
  input  logic [CNT_W-1:0]     fifoFree,
  input  logic                 memReqReady,
  input  logic                 memRspValid,
  output logic                 memReqValid,
  output logic [31:0]          memReqAddr,
  output logic [BLEN_W-1:0]    memReqLen,
  output fetchStrobes_t        strobes
);
  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DRSP, S_SETUP, S_BREQ, S_BRSP, S_DONE} state_e;

  state_e            state;
  logic [1:0]        wordIdx;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       curAddr;
  logic [BLEN_W-1:0] rspLeft;
  logic [BLEN_W-1:0] fullLen;
  logic [BLEN_W-1:0] chunkLen;
  logic              room;

  always_comb begin
    case (burstSel)
      2'd0:    fullLen = BLEN_W'(4);
      2'd1:    fullLen = BLEN_W'(8);
      default: fullLen = BLEN_W'(MAX_BURST);
    endcase
    chunkLen = (remain < LEN_W'(fullLen)) ? BLEN_W'(remain) : fullLen;
    room     = int'(fifoFree) >= int'(fullLen);
  end

  always_comb begin
    memReqValid = 1'b0;
    memReqAddr  = headPtr;
    memReqLen   = BLEN_W'(4);
    if (state == S_DREQ) begin
      memReqValid = 1'b1;
    end else if (state == S_BREQ) begin
      memReqValid = room;
      memReqAddr  = curAddr;
      memReqLen   = chunkLen;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.word    = descWord_e'(wordIdx);
    strobes.capture = (state == S_DRSP) && memRspValid;
    strobes.push    = (state == S_BRSP) && memRspValid;
    strobes.markSof = (state == S_SETUP) && cmdSof;
    strobes.markEof = (state == S_DONE) && cmdEof;
    strobes.advance = (state == S_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      remain  <= '0;
      curAddr <= '0;
      rspLeft <= '0;
    end else begin
      case (state)
        S_IDLE: if (run) state <= S_DREQ;
        S_DREQ: if (memReqReady) begin
          state   <= S_DRSP;
          wordIdx <= '0;
        end
        S_DRSP: if (memRspValid) begin
          wordIdx <= wordIdx + 2'd1;
          if (wordIdx == 2'd3) state <= S_SETUP;
        end
        S_SETUP: begin
          remain  <= cmdLen;
          curAddr <= srcAddr;
          state   <= (cmdLen == '0) ? S_DONE : S_BREQ;
        end
        S_BREQ: if (room && memReqReady) begin
          remain  <= remain - LEN_W'(chunkLen);
          curAddr <= curAddr + (32'(chunkLen) << 2);
          rspLeft <= chunkLen;
          state   <= S_BRSP;
        end
        S_BRSP: if (memRspValid) begin
          rspLeft <= rspLeft - BLEN_W'(1);
          if (rspLeft == BLEN_W'(1)) state <= (remain == '0) ? S_DONE : S_BREQ;
        end
        S_DONE:  state <= run ? S_DREQ : S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dfetch_datapath.sv
module dfetch_datapath
  import dfetch_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LEN_W      = 24,
  localparam int unsigned PTR_W     = $clog2(FIFO_DEPTH),
  localparam int unsigned CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  fetchStrobes_t    strobes,
  input  logic [31:0]      memRspData,
  input  logic             pixDe,
  output logic [31:0]      pixData,
  output logic             irq,
  output logic             run,
  output logic [1:0]       burstSel,
  output logic [31:0]      headPtr,
  output logic [31:0]      srcAddr,
  output logic [LEN_W-1:0] cmdLen,
  output logic             cmdSof,
  output logic             cmdEof,
  output logic [CNT_W-1:0] fifoFree
);
  logic        ctrlRun, ctrlUdet, ctrlUirq;
  logic [1:0]  ctrlBurst;
  logic [31:0] headReg;
  logic [2:0]  statReg, statNext;   // {eof, sof, underrun}
  logic [31:0] descWords [4];

  logic [31:0]      fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             empty, doPop, underHit;

  assign empty    = (count == '0);
  assign doPop    = pixDe && !empty;
  assign underHit = pixDe && empty && ctrlUdet;
  assign pixData  = doPop ? fifoMem[rdPtr] : '0;
  assign fifoFree = CNT_W'(FIFO_DEPTH) - count;

  // one capture register per descriptor word
  for (genvar w = 0; w < 4; w++) begin : g_desc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) descWords[w] <= '0;
      else if (strobes.capture && (strobes.word == descWord_e'(w))) descWords[w] <= memRspData;
    end
  end

  always_comb begin
    statNext = statReg;
    if (regWrEn && regAddr == OFS_STAT) statNext = statNext & regWrData[2:0];
    if (underHit)        statNext[0] = 1'b1;
    if (strobes.markSof) statNext[1] = 1'b1;
    if (strobes.markEof) statNext[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlRun   <= 1'b0;
      ctrlUdet  <= 1'b0;
      ctrlUirq  <= 1'b0;
      ctrlBurst <= '0;
      headReg   <= '0;
      statReg   <= '0;
    end else begin
      if (regWrEn && regAddr == OFS_CTRL) begin
        ctrlRun   <= regWrData[CTRL_RUN];
        ctrlUdet  <= regWrData[CTRL_UDET];
        ctrlUirq  <= regWrData[CTRL_UIRQ];
        ctrlBurst <= regWrData[CTRL_BLO +: 2];
      end
      if (regWrEn && regAddr == OFS_HEAD) headReg <= regWrData;
      else if (strobes.advance)           headReg <= descWords[W_LINK];
      statReg <= statNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)        rdPtr <= rdPtr + PTR_W'(1);
      case ({strobes.push, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) fifoMem[wrPtr] <= memRspData;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdData[CTRL_RUN]       = ctrlRun;
        regRdData[CTRL_UDET]      = ctrlUdet;
        regRdData[CTRL_UIRQ]      = ctrlUirq;
        regRdData[CTRL_BLO +: 2]  = ctrlBurst;
      end
      OFS_STAT: regRdData = {29'd0, statReg};
      OFS_HEAD: regRdData = headReg;
      OFS_SRC:  regRdData = descWords[W_SRC];
      OFS_FID:  regRdData = descWords[W_FID];
      OFS_CMD:  regRdData = descWords[W_CMD];
      default:  regRdData = '0;
    endcase
  end

  assign irq      = statReg[1] | statReg[2] | (statReg[0] & ctrlUirq);
  assign run      = ctrlRun;
  assign burstSel = ctrlBurst;
  assign headPtr  = headReg;
  assign srcAddr  = descWords[W_SRC];
  assign cmdLen   = descWords[W_CMD][LEN_W-1:0];
  assign cmdSof   = descWords[W_CMD][CMD_SOF];
  assign cmdEof   = descWords[W_CMD][CMD_EOF];
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
  import dfetch_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LEN_W      = 24,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [31:0]       memReqAddr,
  output logic [BLEN_W-1:0] memReqLen,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  input  logic              pixDe,
  output logic [31:0]       pixData,
  output logic              irq
);
  fetchStrobes_t    strobes;
  logic             run, cmdSof, cmdEof;
  logic [1:0]       burstSel;
  logic [31:0]      headPtr, srcAddr;
  logic [LEN_W-1:0] cmdLen;
  logic [CNT_W-1:0] fifoFree;

  dfetch_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .burstSel(burstSel), .headPtr(headPtr),
    .srcAddr(srcAddr), .cmdLen(cmdLen), .cmdSof(cmdSof), .cmdEof(cmdEof),
    .fifoFree(fifoFree), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqLen(memReqLen),
    .strobes(strobes)
  );

  dfetch_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobes(strobes),
    .memRspData(memRspData), .pixDe(pixDe), .pixData(pixData), .irq(irq),
    .run(run), .burstSel(burstSel), .headPtr(headPtr), .srcAddr(srcAddr),
    .cmdLen(cmdLen), .cmdSof(cmdSof), .cmdEof(cmdEof), .fifoFree(fifoFree)
  );
endmodule

// File: rtl/dfetch_checker.sv
module dfetch_checker
  import dfetch_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [31:0]       memReqAddr,
  input logic [BLEN_W-1:0] memReqLen,
  input logic              memRspValid,
  input logic              pixDe,
  input logic [31:0]       pixData,
  input logic              irq,
  input fetchStrobes_t     strobes,
  input logic [CNT_W-1:0]  fifoFree
);
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr) && $stable(memReqLen)));

  p_push_on_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |-> memRspValid);

  p_len_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqLen != '0 && int'(memReqLen) <= int'(MAX_BURST)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |-> (fifoFree != '0));

  p_sof_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markSof |=> irq);

  p_eof_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markEof |=> irq);

  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixDe && int'(fifoFree) == int'(FIFO_DEPTH)) |-> (pixData == '0));
endmodule

bind dfetch_top dfetch_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_dfetch_checker (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memReqLen(memReqLen), .memRspValid(memRspValid),
  .pixDe(pixDe), .pixData(pixData), .irq(irq), .strobes(strobes), .fifoFree(fifoFree)
);

// File: tb/test_dfetch_top.sv
module test_dfetch_top;
  import dfetch_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [7:0]        regAddr = 8'h30;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              memReqValid;
  logic              memReqReady = 1'b1;
  logic [31:0]       memReqAddr;
  logic [BLEN_W-1:0] memReqLen;
  logic              memRspValid = 1'b0;
  logic [31:0]       memRspData = '0;
  logic              pixDe = 1'b0;
  logic [31:0]       pixData;
  logic              irq;

  always #10 clk = ~clk;   // 50 MHz

  dfetch_top i_dfetch_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memReqLen(memReqLen),
    .memRspValid(memRspValid), .memRspData(memRspData), .pixDe(pixDe),
    .pixData(pixData), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural memory: 256 words, byte addressed
  logic [31:0] mem [256];
  logic [31:0] pendAddr = '0;
  int          pendLeft = 0;
  int          reqCount = 0;
  int          lastLen  = 0;
  int          descHits = 0;
  logic [31:0] watchAddr = 32'hFFFF_FFFF;
  logic        stall = 1'b0;

  always @(posedge clk) begin
    if (memReqValid === 1'b1 && memReqReady) begin
      pendAddr = memReqAddr;
      pendLeft = int'(memReqLen);
      reqCount++;
      lastLen = int'(memReqLen);
      if (memReqAddr == watchAddr && memReqLen == BLEN_W'(4)) descHits++;
    end
  end

  always @(negedge clk) begin
    memReqReady <= stall ? ~memReqReady : 1'b1;
    if (pendLeft > 0) begin
      memRspValid <= 1'b1;
      memRspData  <= mem[pendAddr[9:2]];
      pendAddr    = pendAddr + 32'd4;
      pendLeft--;
    end else begin
      memRspValid <= 1'b0;
    end
  end

  logic [31:0] gotWords [64];
  int          gotN;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input int want, input int maxCyc);
    gotN = 0;
    for (int c = 0; c < maxCyc && gotN < want && gotN < 64; c++) begin
      @(negedge clk);
      pixDe = 1'b1;
      #1;
      if (pixData != 0) begin
        gotWords[gotN] = pixData;
        gotN++;
      end
    end
    @(negedge clk);
    pixDe = 1'b0;
  endtask

  task automatic setDesc(input int base, input logic [31:0] link, input logic [31:0] src,
                         input logic [31:0] fid, input logic [31:0] cmd);
    mem[base >> 2]       = link;
    mem[(base >> 2) + 1] = src;
    mem[(base >> 2) + 2] = fid;
    mem[(base >> 2) + 3] = cmd;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  typedef struct packed {
    logic [1:0] bsel;
    logic [7:0] len;
    logic [7:0] nBursts;
    logic [7:0] lastLen;
    logic       sof;
    logic       eof;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'd10, 8'd3, 8'd2,  1'b1, 1'b1},
    '{2'd1, 8'd8,  8'd1, 8'd8,  1'b0, 1'b1},
    '{2'd2, 8'd20, 8'd2, 8'd4,  1'b1, 1'b0},
    '{2'd0, 8'd4,  8'd1, 8'd4,  1'b0, 1'b0},
    '{2'd1, 8'd3,  8'd1, 8'd3,  1'b1, 1'b0},
    '{2'd3, 8'd24, 8'd2, 8'd8,  1'b0, 1'b1},
    '{2'd2, 8'd40, 8'd3, 8'd8,  1'b1, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] v;
    int bad;
    logic [31:0] cmd;

    for (int i = 0; i < 256; i++) mem[i] = (i >= 16) ? (32'hA500_0000 | 32'(i)) : 32'd0;

    idle(3);
    rstN = 1'b1;
    idle(2);

    // R10 reset state
    rd(OFS_CTRL, v); chk("R10 ctrl", v, 32'd0);
    rd(OFS_STAT, v); chk("R10 status", v, 32'd0);
    rd(OFS_HEAD, v); chk("R10 head", v, 32'd0);
    chk("R10 no request", 32'(memReqValid), 32'd0);
    chk("R10 irq", 32'(irq), 32'd0);

    // table of single-descriptor frames
    for (int k = 0; k < NVEC; k++) begin
      cmd = (32'(VECS[k].sof) << 31) | (32'(VECS[k].eof) << 30) | 32'(VECS[k].len);
      if (k == 3) cmd = cmd | 32'h1000_0000;
      setDesc(0, 32'h0, 32'h100, 32'h1000 + 32'(k), cmd);
      stall = k[0];
      wr(OFS_HEAD, 32'h0);
      wr(OFS_STAT, 32'h0);
      reqCount = 0;
      wr(OFS_CTRL, (32'(VECS[k].bsel) << 28) | 32'h8);
      wr(OFS_CTRL, (32'(VECS[k].bsel) << 28));
      drain(int'(VECS[k].len), 600);
      idle(20);
      stall = 1'b0;
      bad = 0;
      for (int i = 0; i < gotN; i++) if (gotWords[i] != mem[64 + i]) bad++;
      chk("R3 word count", 32'(gotN), 32'(VECS[k].len));
      chk("R3 word order", 32'(bad), 32'd0);
      chk("R4 request count", 32'(reqCount), 32'(VECS[k].nBursts) + 32'd1);
      chk("R4 last burst length", 32'(lastLen), 32'(VECS[k].lastLen));
      rd(OFS_STAT, v);
      chk("R6 status flags", v, {29'd0, VECS[k].eof, VECS[k].sof, 1'b0});
      chk("R9 irq from flags", 32'(irq), 32'(VECS[k].eof | VECS[k].sof));
      rd(OFS_FID, v); chk("R2 frame id mirror", v, 32'h1000 + 32'(k));
      rd(OFS_CMD, v); chk("R2 command mirror", v, cmd);
      rd(OFS_HEAD, v); chk("R7 head follows self link", v, 32'h0);
    end

    // R2 read-only mirrors ignore writes, head is writable
    wr(OFS_SRC, 32'hDEAD_0001);
    wr(OFS_FID, 32'hDEAD_0002);
    wr(OFS_CMD, 32'hDEAD_0003);
    rd(OFS_SRC, v); chk("R2 src write ignored", v, 32'h100);
    rd(OFS_FID, v); chk("R2 fid write ignored", v, 32'h1006);
    rd(OFS_CMD, v); chk("R2 cmd write ignored", v, 32'hC000_0028);
    wr(OFS_HEAD, 32'h20);
    rd(OFS_HEAD, v); chk("R2 head writable", v, 32'h20);

    // R5 a burst waits for full-burst room
    setDesc(16, 32'h10, 32'h100, 32'h55, 32'd40);
    wr(OFS_HEAD, 32'h10);
    reqCount = 0;
    wr(OFS_CTRL, 32'h2000_0008);
    wr(OFS_CTRL, 32'h2000_0000);
    idle(100);
    chk("R5 stalls with full fifo", 32'(reqCount), 32'd3);
    drain(8, 20);
    idle(30);
    chk("R5 partial room not enough", 32'(reqCount), 32'd3);
    drain(8, 20);
    idle(30);
    chk("R5 burst after room", 32'(reqCount), 32'd4);
    chk("R4 shortened tail", 32'(lastLen), 32'd8);
    drain(24, 200);
    chk("R5 remaining words", 32'(gotN), 32'd24);
    idle(10);

    // R8 / R9 underrun
    wr(OFS_CTRL, 32'h0400_0800);
    wr(OFS_STAT, 32'h0);
    @(negedge clk); pixDe = 1'b1; #1;
    chk("R8 zero on underrun", pixData, 32'd0);
    @(negedge clk); pixDe = 1'b0;
    rd(OFS_STAT, v); chk("R8 underrun sticky", v, 32'd1);
    chk("R9 underrun irq enabled", 32'(irq), 32'd1);
    wr(OFS_STAT, 32'hFFFF_FFFE);
    rd(OFS_STAT, v); chk("R9 write zero clears", v, 32'd0);
    chk("R9 irq cleared", 32'(irq), 32'd0);
    wr(OFS_CTRL, 32'h0400_0000);
    @(negedge clk); pixDe = 1'b1;
    @(negedge clk); pixDe = 1'b0;
    rd(OFS_STAT, v); chk("R8 underrun flag masked irq", v, 32'd1);
    chk("R9 irq masked", 32'(irq), 32'd0);
    wr(OFS_STAT, 32'h0);
    wr(OFS_CTRL, 32'h0);
    @(negedge clk); pixDe = 1'b1;
    @(negedge clk); pixDe = 1'b0;
    rd(OFS_STAT, v); chk("R8 detect off ignored", v, 32'd0);

    // R7 chain then self-linked refresh
    setDesc(32, 32'h30, 32'h100, 32'hA, 32'd4);
    setDesc(48, 32'h30, 32'h140, 32'hB, 32'd4);
    watchAddr = 32'h30;
    descHits = 0;
    wr(OFS_HEAD, 32'h20);
    wr(OFS_CTRL, 32'h8);
    drain(12, 400);
    bad = 0;
    for (int i = 0; i < 4; i++) if (gotWords[i] != mem[64 + i]) bad++;
    for (int i = 4; i < 12; i++) if (gotWords[i] != mem[80 + ((i - 4) % 4)]) bad++;
    chk("R7 chain order and refresh", 32'(bad), 32'd0);
    chk("R7 self link refetched", 32'(descHits >= 2), 32'd1);
    wr(OFS_CTRL, 32'h0);
    drain(64, 300);
    idle(20);
    rd(OFS_HEAD, v); chk("R7 head at tail", v, 32'h30);
    rd(OFS_FID, v); chk("R1 tail id loaded", v, 32'hB);
    rd(OFS_SRC, v); chk("R1 tail src loaded", v, 32'h140);

    // R6 zero-length descriptor
    setDesc(0, 32'h10, 32'h100, 32'h77, 32'h4000_0000);
    wr(OFS_HEAD, 32'h0);
    wr(OFS_STAT, 32'h0);
    reqCount = 0;
    wr(OFS_CTRL, 32'h8);
    wr(OFS_CTRL, 32'h0);
    idle(20);
    chk("R6 zero length only descriptor read", 32'(reqCount), 32'd1);
    rd(OFS_STAT, v); chk("R6 eof on zero length", v, 32'd4);
    rd(OFS_HEAD, v); chk("R7 head advanced", v, 32'h10);

    summary();
  end
endmodule